// File: doc/BRIEF.md
# Phase/Frequency Detector with Mode Selector

This block turns sampled timing events into charge-pump commands for a clock-recovery loop. Everything runs on one fast oversampling clock: the received data, the oscillator output and the crystal reference arrive as single-bit levels sampled by that clock. From them the block produces two mutually exclusive pump commands, `pump_up` and `pump_dn`, and brings out the recovered clock that it actually uses.

Two detectors share the pump outputs. The phase detector runs while `freq_mode` is low. A rising edge on the received data opens an UP pulse. The pulse closes at the next rising edge of the recovered clock, so its width follows the phase error. A DOWN pulse of fixed width always comes right after it, and this keeps the net gain independent of the data pattern. The frequency detector runs while `freq_mode` is high. It counts reference edges and recovered-clock edges over a fixed window and issues one fixed-width UP or DOWN pulse when the counts differ. This pulls the oscillator close to the reference before phase tracking starts. When `low_rate` is high, the recovered clock is the oscillator divided by four, for the slower line rate.

A pulse sequence that has started always runs to its end. The mode input is consulted only while no sequence is active.

Top module: `pfd_mode_sel`

## Requirements
- R1: While reset is asserted and right after it is released, `pump_up`, `pump_dn` and `rclk_out` are all 0.
- R2: In phase mode, a data rising edge sampled at clock edge e raises `pump_up` after e. If `vco_clk` is first sampled high at edge e+D (full rate, D small), `pump_up` stays high for exactly D+1 cycles.
- R3: A phase-mode UP pulse saturates at VCO_PER cycles at full rate and at DIV*VCO_PER cycles at low rate (defaults 8 and 32).
- R4: Every phase-mode UP pulse is followed in the very next cycle by a DOWN pulse of exactly DN_W cycles (default 3), whatever the width of the UP pulse.
- R5: `pump_up` and `pump_dn` are never high in the same cycle.
- R6: In frequency mode, after each WIN-cycle window (default 64) a single pulse of DN_W cycles is issued. It is on `pump_up` if the reference had more rising edges than the recovered clock, on `pump_dn` if it had fewer, and no pulse is issued if the counts are equal.
- R7: The input of the detector that is not selected has no effect. Data edges in frequency mode and count differences in phase mode produce no pulses.
- R8: A change of `freq_mode` during a sequence does not shorten or alter that sequence.
- R9: With `low_rate` low, `rclk_out` equals `vco_clk` delayed by one clock. With `low_rate` high, `rclk_out` is the MSB of a 2-bit counter of `vco_clk` rising edges that starts at 0 after reset, so it goes high after the 2nd rise and low after the 4th.
- R10: Further data rising edges during an active phase sequence neither restart it nor extend it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| data_in | input | 1 | Sampled received data |
| vco_clk | input | 1 | Sampled oscillator output |
| ref_clk | input | 1 | Sampled crystal reference |
| freq_mode | input | 1 | 1 = frequency acquisition, 0 = phase tracking |
| low_rate | input | 1 | 1 = recovered clock is the oscillator divided by 4 |
| pump_up | output | 1 | Charge-pump UP command |
| pump_dn | output | 1 | Charge-pump DOWN command |
| rclk_out | output | 1 | Selected recovered clock |

## Verification
Two events can fall in the same cycle. A recovered-clock edge that ends an UP pulse can coincide with a new data edge or with a mode switch, and a window result can arrive while a phase sequence is still running. The bench provokes both cases. It toggles data and flips `freq_mode` in the middle of an UP pulse, and it runs the frequency comparator while a phase sequence is active. It then judges the outcome by counting UP and DOWN cycles and checking their order, and it checks on every sampled cycle that the two commands never overlap.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_PUP  = 3'd1,
    SQ_PDN  = 3'd2,
    SQ_FUP  = 3'd3,
    SQ_FDN  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic lvl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= sig;
  end

  assign rise = sig & ~lvl_q;
endmodule

// File: rtl/pfd_clk_path.sv
module pfd_clk_path #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vco_clk,
  input  logic low_rate,
  output logic rclk_sel,
  output logic rclk_rise
);
  logic vco_rise;
  logic vco_q;
  logic div_clk;
  logic rclk_q;

  pfd_edge_det u_vco_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (vco_clk),
    .rise  (vco_rise),
    .lvl_q (vco_q)
  );

  generate
    if (DIV > 1) begin : g_div
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] div_cnt;
      logic [DW-1:0] div_nx;

      always_comb begin
        div_nx = div_cnt;
        if (vco_rise) div_nx = div_cnt + DW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_nx;
      end

      assign div_clk = div_cnt[DW-1];
    end else begin : g_nodiv
      assign div_clk = vco_q;
    end
  endgenerate

  assign rclk_sel = low_rate ? div_clk : vco_q;

  pfd_edge_det u_rclk_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (rclk_sel),
    .rise  (rclk_rise),
    .lvl_q (rclk_q)
  );
endmodule

// File: rtl/pfd_freq_cmp.sv
module pfd_freq_cmp #(
  parameter int WIN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic fd_valid,
  output logic fd_up,
  output logic fd_dn
);
  localparam int WW   = $clog2(WIN);
  localparam int CNTW = $clog2(WIN + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN - 1);

  logic [WW-1:0]   win_cnt, win_nx;
  logic [CNTW-1:0] ref_n, ref_nx, fb_n, fb_nx;
  logic [CNTW-1:0] ref_tot, fb_tot;
  logic            end_win;
  logic            valid_nx, up_nx, dn_nx;

  assign ref_tot = ref_n + CNTW'(ref_rise);
  assign fb_tot  = fb_n + CNTW'(fb_rise);
  assign end_win = (win_cnt == WIN_LAST);

  always_comb begin
    win_nx   = end_win ? '0 : win_cnt + WW'(1);
    ref_nx   = end_win ? '0 : ref_tot;
    fb_nx    = end_win ? '0 : fb_tot;
    valid_nx = end_win;
    up_nx    = end_win && (ref_tot > fb_tot);
    dn_nx    = end_win && (ref_tot < fb_tot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      ref_n    <= '0;
      fb_n     <= '0;
      fd_valid <= 1'b0;
      fd_up    <= 1'b0;
      fd_dn    <= 1'b0;
    end else begin
      win_cnt  <= win_nx;
      ref_n    <= ref_nx;
      fb_n     <= fb_nx;
      fd_valid <= valid_nx;
      fd_up    <= up_nx;
      fd_dn    <= dn_nx;
    end
  end
endmodule

// File: rtl/pfd_seq.sv
module pfd_seq
  import pfd_pkg::*;
#(
  parameter int UP_HI = 8,
  parameter int UP_LO = 32,
  parameter int DN_W  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freq_mode,
  input  logic low_rate,
  input  logic data_rise,
  input  logic rclk_rise,
  input  logic fd_valid,
  input  logic fd_up,
  input  logic fd_dn,
  output logic pump_up,
  output logic pump_dn
);
  localparam int CW = $clog2(UP_LO + DN_W + 1);
  localparam logic [CW-1:0] HI_LAST = CW'(UP_HI - 1);
  localparam logic [CW-1:0] LO_LAST = CW'(UP_LO - 1);
  localparam logic [CW-1:0] DN_LAST = CW'(DN_W - 1);

  seq_state_e    state, state_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic [CW-1:0] up_last;

  assign up_last = low_rate ? LO_LAST : HI_LAST;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt + CW'(1);
    unique case (state)
      SQ_IDLE: begin
        cnt_nx = '0;
        if (freq_mode) begin
          if (fd_valid && fd_up)      state_nx = SQ_FUP;
          else if (fd_valid && fd_dn) state_nx = SQ_FDN;
        end else if (data_rise) begin
          state_nx = SQ_PUP;
        end
      end
      SQ_PUP: begin
        if (rclk_rise || cnt == up_last) begin
          state_nx = SQ_PDN;
          cnt_nx   = '0;
        end
      end
      SQ_PDN, SQ_FUP, SQ_FDN: begin
        if (cnt == DN_LAST) begin
          state_nx = SQ_IDLE;
          cnt_nx   = '0;
        end
      end
      default: begin
        state_nx = SQ_IDLE;
        cnt_nx   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  assign pump_up = (state == SQ_PUP) || (state == SQ_FUP);
  assign pump_dn = (state == SQ_PDN) || (state == SQ_FDN);
endmodule

// File: rtl/pfd_mode_sel.sv
module pfd_mode_sel #(
  parameter int VCO_PER = 8,
  parameter int DIV     = 4,
  parameter int DN_W    = 3,
  parameter int WIN     = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  input  logic vco_clk,
  input  logic ref_clk,
  input  logic freq_mode,
  input  logic low_rate,
  output logic pump_up,
  output logic pump_dn,
  output logic rclk_out
);
  localparam int UP_HI = VCO_PER;
  localparam int UP_LO = VCO_PER * DIV;

  logic data_rise, data_q;
  logic ref_rise, ref_q;
  logic rclk_sel, rclk_rise;
  logic fd_valid, fd_up, fd_dn;

  pfd_edge_det u_data_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (data_in),
    .rise  (data_rise),
    .lvl_q (data_q)
  );

  pfd_edge_det u_ref_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (ref_clk),
    .rise  (ref_rise),
    .lvl_q (ref_q)
  );

  pfd_clk_path #(.DIV(DIV)) u_clk_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .vco_clk   (vco_clk),
    .low_rate  (low_rate),
    .rclk_sel  (rclk_sel),
    .rclk_rise (rclk_rise)
  );

  pfd_freq_cmp #(.WIN(WIN)) u_freq_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (ref_rise),
    .fb_rise  (rclk_rise),
    .fd_valid (fd_valid),
    .fd_up    (fd_up),
    .fd_dn    (fd_dn)
  );

  pfd_seq #(.UP_HI(UP_HI), .UP_LO(UP_LO), .DN_W(DN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_mode (freq_mode),
    .low_rate  (low_rate),
    .data_rise (data_rise),
    .rclk_rise (rclk_rise),
    .fd_valid  (fd_valid),
    .fd_up     (fd_up),
    .fd_dn     (fd_dn),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn)
  );

  assign rclk_out = rclk_sel;
endmodule

// File: rtl/pfd_mode_sel_chk.sv
module pfd_mode_sel_chk #(
  parameter int VCO_PER = 8,
  parameter int DIV     = 4,
  parameter int DN_W    = 3
) (
  input logic clk,
  input logic rst_n,
  input logic vco_clk,
  input logic low_rate,
  input logic pump_up,
  input logic pump_dn,
  input logic rclk_out
);
  localparam int UP_LO = VCO_PER * DIV;
  localparam int RW    = $clog2(UP_LO + DN_W + 2);

  logic [RW-1:0] up_run, dn_run;
  logic          warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_run <= '0;
      dn_run <= '0;
      warm   <= 1'b0;
    end else begin
      warm   <= 1'b1;
      up_run <= pump_up ? ((up_run == '1) ? up_run : up_run + RW'(1)) : '0;
      dn_run <= pump_dn ? ((dn_run == '1) ? dn_run : dn_run + RW'(1)) : '0;
    end
  end

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  // R4
  dn_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $fell(pump_dn)) |-> (dn_run == RW'(DN_W)));

  // R3
  up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pump_up |-> (up_run < RW'(UP_LO)));

  // R8
  seq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(pump_up)) |-> !$past(pump_dn));

  // R9
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !low_rate && !$past(low_rate)) |-> (rclk_out == $past(vco_clk)));
endmodule

bind pfd_mode_sel pfd_mode_sel_chk #(
  .VCO_PER (VCO_PER),
  .DIV     (DIV),
  .DN_W    (DN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vco_clk  (vco_clk),
  .low_rate (low_rate),
  .pump_up  (pump_up),
  .pump_dn  (pump_dn),
  .rclk_out (rclk_out)
);

// File: tb/pfd_mode_sel_tb.sv
module pfd_mode_sel_tb;
  localparam int VCO_PER = 8;
  localparam int DIV     = 4;
  localparam int DN_W    = 3;
  localparam int WIN     = 64;
  localparam int NEVER   = 255;

  logic clk = 1'b0;
  logic rst_n;
  logic data_in, man_vco, freq_mode, low_rate;
  logic gen_en;
  int   ref_per, vco_per, tcnt;
  logic gen_ref, gen_vco;
  logic vco_clk, ref_clk;
  logic pump_up, pump_dn, rclk_out;

  int checks = 0;
  int errors = 0;
  int overlap = 0;

  always #5 clk = ~clk;

  assign gen_ref = gen_en && ((tcnt % ref_per) < (ref_per / 2));
  assign gen_vco = gen_en && ((tcnt % vco_per) < (vco_per / 2));
  assign ref_clk = gen_en ? gen_ref : 1'b0;
  assign vco_clk = gen_en ? gen_vco : man_vco;

  pfd_mode_sel #(.VCO_PER(VCO_PER), .DIV(DIV), .DN_W(DN_W), .WIN(WIN)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_in   (data_in),
    .vco_clk   (vco_clk),
    .ref_clk   (ref_clk),
    .freq_mode (freq_mode),
    .low_rate  (low_rate),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .rclk_out  (rclk_out)
  );

  always @(negedge clk) begin
    tcnt <= tcnt + 1;
    if (rst_n && pump_up && pump_dn) overlap <= overlap + 1;
  end

  // fields: low_rate, delay to vco rise, retoggle, mode switch, exp up, exp dn
  localparam logic [47:0] VEC [8] = '{
    {8'd0, 8'd0,  8'd0, 8'd0, 8'd1,  8'd3},
    {8'd0, 8'd2,  8'd0, 8'd0, 8'd3,  8'd3},
    {8'd0, 8'd5,  8'd0, 8'd0, 8'd6,  8'd3},
    {8'd0, 8'd7,  8'd0, 8'd0, 8'd8,  8'd3},
    {8'd0, 8'd255,8'd0, 8'd0, 8'd8,  8'd3},
    {8'd1, 8'd255,8'd0, 8'd0, 8'd32, 8'd3},
    {8'd0, 8'd4,  8'd1, 8'd0, 8'd5,  8'd3},
    {8'd0, 8'd255,8'd0, 8'd1, 8'd8,  8'd3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_win(input int n, output int ups, output int dns);
    ups = 0;
    dns = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pump_up) ups++;
      if (pump_dn) dns++;
    end
  endtask

  task automatic run_phase(input logic [47:0] v);
    int lr, dly, rt, sw, eu, ed, ups, dns, order_err;
    bit seen_dn;
    lr  = int'(v[47:40]);
    dly = int'(v[39:32]);
    rt  = int'(v[31:24]);
    sw  = int'(v[23:16]);
    eu  = int'(v[15:8]);
    ed  = int'(v[7:0]);
    @(negedge clk);
    data_in = 1'b0; man_vco = 1'b0; freq_mode = 1'b0; low_rate = lr[0];
    repeat (6) @(negedge clk);
    ups = 0; dns = 0; order_err = 0; seen_dn = 0;
    for (int i = 0; i < 60; i++) begin
      if (i > 0) begin
        if (pump_up) begin
          ups++;
          if (seen_dn) order_err++;
        end
        if (pump_dn) begin
          dns++;
          seen_dn = 1;
          if (ups == 0) order_err++;
        end
      end
      if (i == 0) data_in = 1'b1;
      if (rt != 0 && i == 1) data_in = 1'b0;
      if (rt != 0 && i == 2) data_in = 1'b1;
      if (sw != 0 && i == 2) freq_mode = 1'b1;
      if (i == dly) man_vco = 1'b1;
      @(negedge clk);
    end
    if (rt != 0)       chk(ups == eu, "R10 up width with data retoggle", ups, eu);
    else if (sw != 0)  chk(ups == eu, "R8 up width across mode switch", ups, eu);
    else if (dly == NEVER) chk(ups == eu, "R3 up saturation", ups, eu);
    else               chk(ups == eu, "R2 up width vs phase", ups, eu);
    chk(dns == ed, "R4 down width", dns, ed);
    chk(order_err == 0, "R4 down follows up", order_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ups, dns;
    int exp_div [4] = '{0, 1, 1, 0};
    rst_n = 1'b0; tcnt = 0; gen_en = 1'b0; ref_per = 8; vco_per = 8;
    data_in = 1'b0; man_vco = 1'b0; freq_mode = 1'b0; low_rate = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pump_up && !pump_dn && !rclk_out, "R1 outputs in reset",
        {pump_up, pump_dn, rclk_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pump_up && !pump_dn && !rclk_out, "R1 outputs after release",
        {pump_up, pump_dn, rclk_out}, 0);

    // R9 divide-by-4 path from reset
    low_rate = 1'b1;
    for (int r = 0; r < 4; r++) begin
      man_vco = 1'b1;
      @(negedge clk);
      chk(rclk_out == exp_div[r][0], "R9 divided clock", rclk_out, exp_div[r]);
      man_vco = 1'b0;
      @(negedge clk);
    end
    // R9 full-rate pass-through
    low_rate = 1'b0;
    man_vco = 1'b1;
    @(negedge clk);
    chk(rclk_out == 1'b1, "R9 full rate high", rclk_out, 1);
    man_vco = 1'b0;
    @(negedge clk);
    chk(rclk_out == 1'b0, "R9 full rate low", rclk_out, 0);

    for (int v = 0; v < 8; v++) run_phase(VEC[v]);

    // R6 frequency mode: reference faster
    @(negedge clk);
    freq_mode = 1'b0; data_in = 1'b0; man_vco = 1'b0; low_rate = 1'b0;
    ref_per = 4; vco_per = 8; gen_en = 1'b1; freq_mode = 1'b1;
    repeat (130) @(negedge clk);
    count_win(4 * WIN, ups, dns);
    chk(ups == 4 * DN_W, "R6 ref faster up cycles", ups, 4 * DN_W);
    chk(dns == 0, "R6 ref faster down cycles", dns, 0);

    // R6 reference slower
    ref_per = 8; vco_per = 4;
    repeat (130) @(negedge clk);
    count_win(4 * WIN, ups, dns);
    chk(dns == 4 * DN_W, "R6 ref slower down cycles", dns, 4 * DN_W);
    chk(ups == 0, "R6 ref slower up cycles", ups, 0);

    // R6 equal rates, R7 data edges ignored in frequency mode
    ref_per = 8; vco_per = 8;
    repeat (130) @(negedge clk);
    ups = 0; dns = 0;
    for (int i = 0; i < 4 * WIN; i++) begin
      data_in = (i % 6) < 3;
      @(negedge clk);
      if (pump_up) ups++;
      if (pump_dn) dns++;
    end
    chk(ups == 0 && dns == 0, "R7 equal rates with data toggling", ups + dns, 0);

    // R7 frequency difference ignored in phase mode
    data_in = 1'b0; freq_mode = 1'b0; ref_per = 4; vco_per = 8;
    repeat (10) @(negedge clk);
    count_win(4 * WIN, ups, dns);
    chk(ups == 0 && dns == 0, "R7 phase mode ignores ref", ups + dns, 0);
    gen_en = 1'b0;
    repeat (4) @(negedge clk);

    chk(overlap == 0, "R5 up and down never together", overlap, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule